// File: doc/BRIEF.md
# Counter Channel Interrupt Collector

This block sits beside a bank of counter channels and turns their event pulses into one interrupt request for a host. Each channel delivers a trigger line. A rising edge on that line is latched as a pending flag, but only when the host has enabled that channel. The pending flags can be read as one status word, and a status of zero means nothing is waiting.

A command register controls the whole bank. One command code stops the counters, disables the interrupt function and sends a one-cycle reset to the counters. A second code starts the counters, enables the interrupt function and clears every pending flag. The interrupt request is active only while the interrupt function is enabled and at least one flag is pending. Writing any other value to the command register does nothing.

Two more host views come with the block. A cable-monitor register uses active-low enables, and a 0 bit read back from it marks a cable fault on a monitored channel. An index-level view returns the live level of each channel's index input. The host uses a single write strobe and address, and reads are combinational from the same address.

Top module: `cntirq_hub`

## Requirements
- R1: After reset there are no pending flags, all channel enables are 0, the interrupt function is off, `irq_o` and `cnt_run_o` are low, and the cable register (address 3) reads 0xFF because no channel is monitored.
- R2: A 0-to-1 change of `trig_i[k]` on an enabled channel sets pending bit k one clock later. The bit stays set after the trigger falls. A trigger held high does not set the bit again once it has been cleared. Address 0 reads the pending bits in bit k.
- R3: A trigger edge on a channel whose enable bit is 0 never sets that channel's pending bit. The enable register is at address 2, with bit k for channel k.
- R4: Writing 0x04 to address 1 clears every pending bit and sets `cnt_run_o` (interrupt function on) from the next cycle on.
- R5: When a trigger edge and a 0x04 clear write happen in the same cycle, that channel's pending bit ends up set.
- R6: Writing 0x01 to address 1 drops `cnt_run_o` and pulses `cnt_rst_o` high for exactly one cycle. Pending bits are left unchanged.
- R7: `irq_o` is high exactly when the interrupt function is on and at least one pending bit is set.
- R8: Any value other than 0x01 and 0x04 written to address 1 has no effect on the pending bits, on `cnt_run_o` or on `cnt_rst_o`.
- R9: At address 3, writing bit k as 0 turns on monitoring of channel k. Reading bit k gives 0 only when channel k is monitored and `cable_ok_i[k]` is 0; otherwise it gives 1.
- R10: Address 4 reads the live `index_lvl_i`, with channel k in bit k.
- R11: Address 2 reads back the last enable value written. Address 1 and addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Register address for both reads and writes |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Combinational read data for `addr_i` |
| trig_i | input | 8 | Per-channel event trigger lines |
| index_lvl_i | input | 8 | Live index input levels |
| cable_ok_i | input | 8 | Per-channel cable health, 1 = healthy |
| irq_o | output | 1 | Interrupt request |
| cnt_run_o | output | 1 | Counters and interrupt function enabled |
| cnt_rst_o | output | 1 | One-cycle counter reset pulse |

## Verification
The assertions check the following on every cycle:
- the interrupt line stays low while the function is off and never rises without a pending bit;
- pending bits never drop except through a clear command;
- a disabled channel never gains a pending bit;
- the start command always leaves the function on;
- the reset pulse never coincides with the running state.

Only the bench scenarios can show the following:
- the exact cycle in which an edge is latched;
- the edge-beats-clear race;
- that a level held high does not re-trigger;
- that unknown command codes are ignored;
- the composed cable-fault read value.

The bench model follows these through directed and pseudo-random traffic.

// File: rtl/cntirq_pkg.sv
package cntirq_pkg;

    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_CMD    = 3'd1,
        A_ENABLE = 3'd2,
        A_CABLE  = 3'd3,
        A_LEVEL  = 3'd4
    } reg_addr_e;

    localparam logic [7:0] CMD_STOP = 8'h01;
    localparam logic [7:0] CMD_ARM  = 8'h04;

endpackage

// File: rtl/cntirq_edge.sv
module cntirq_edge #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] trig_i,
    output logic [N_CH-1:0] rise_o
);
    typedef struct packed {
        logic [N_CH-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = trig_i;
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_rise
        assign rise_o[k] = trig_i[k] & ~st_q.prev[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cntirq_pend.sv
module cntirq_pend #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] rise_i,
    input  logic [N_CH-1:0] en_i,
    input  logic            clr_i,
    output logic [N_CH-1:0] pend_o
);
    typedef struct packed {
        logic [N_CH-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    // Per channel: a clear drops the flag, but a qualified edge in the same
    // cycle sets it again, so the edge takes priority.
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        logic set_k;
        assign set_k = rise_i[k] & en_i[k];
        always_comb begin
            st_d.pend[k] = (st_q.pend[k] & ~clr_i) | set_k;
        end
    end

    assign pend_o = st_q.pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cntirq_ctrl.sv
module cntirq_ctrl
    import cntirq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int DW   = 8,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [N_CH-1:0] en_o,
    output logic [N_CH-1:0] mon_o,
    output logic            run_o,
    output logic            rst_pulse_o,
    output logic            clr_o
);
    typedef struct packed {
        logic [N_CH-1:0] en;
        logic [N_CH-1:0] mon;
        logic            run;
        logic            rst_p;
    } st_t;

    st_t  st_d, st_q;
    logic cmd_wr;

    assign cmd_wr = wr_en_i && (addr_i == AW'(A_CMD));
    assign clr_o  = cmd_wr && (wr_data_i == DW'(CMD_ARM));

    always_comb begin
        st_d       = st_q;
        st_d.rst_p = 1'b0;
        if (wr_en_i) begin
            case (addr_i)
                AW'(A_ENABLE): st_d.en  = wr_data_i[N_CH-1:0];
                AW'(A_CABLE):  st_d.mon = ~wr_data_i[N_CH-1:0];
                AW'(A_CMD): begin
                    if (wr_data_i == DW'(CMD_ARM)) begin
                        st_d.run = 1'b1;
                    end else if (wr_data_i == DW'(CMD_STOP)) begin
                        st_d.run   = 1'b0;
                        st_d.rst_p = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign en_o        = st_q.en;
    assign mon_o       = st_q.mon;
    assign run_o       = st_q.run;
    assign rst_pulse_o = st_q.rst_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cntirq_hub.sv
module cntirq_hub
    import cntirq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int DW   = 8,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [DW-1:0]   rd_data_o,
    input  logic [N_CH-1:0] trig_i,
    input  logic [N_CH-1:0] index_lvl_i,
    input  logic [N_CH-1:0] cable_ok_i,
    output logic            irq_o,
    output logic            cnt_run_o,
    output logic            cnt_rst_o
);
    logic [N_CH-1:0] rise_vec;
    logic [N_CH-1:0] en_vec;
    logic [N_CH-1:0] mon_vec;
    logic [N_CH-1:0] pend_vec;
    logic            clr_req;
    logic            run_st;
    logic [N_CH-1:0] cable_view;

    cntirq_edge #(.N_CH(N_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (rise_vec)
    );

    cntirq_ctrl #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wr_data_i   (wr_data_i),
        .en_o        (en_vec),
        .mon_o       (mon_vec),
        .run_o       (run_st),
        .rst_pulse_o (cnt_rst_o),
        .clr_o       (clr_req)
    );

    cntirq_pend #(.N_CH(N_CH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise_vec),
        .en_i   (en_vec),
        .clr_i  (clr_req),
        .pend_o (pend_vec)
    );

    // Active-low fault view: 0 only for a monitored channel with a bad cable.
    assign cable_view = ~(mon_vec & ~cable_ok_i);

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            AW'(A_STATUS): rd_data_o[N_CH-1:0] = pend_vec;
            AW'(A_ENABLE): rd_data_o[N_CH-1:0] = en_vec;
            AW'(A_CABLE):  rd_data_o[N_CH-1:0] = cable_view;
            AW'(A_LEVEL):  rd_data_o[N_CH-1:0] = index_lvl_i;
            default:       rd_data_o = '0;
        endcase
    end

    assign cnt_run_o = run_st;
    assign irq_o     = run_st & (|pend_vec);
endmodule

// File: rtl/cntirq_chk.sv
module cntirq_chk
    import cntirq_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int DW   = 8,
    parameter int AW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en_i,
    input logic [AW-1:0]   addr_i,
    input logic [DW-1:0]   wr_data_i,
    input logic            irq_o,
    input logic            cnt_run_o,
    input logic            cnt_rst_o,
    input logic [N_CH-1:0] pend,
    input logic [N_CH-1:0] en
);
    logic arm_wr;
    assign arm_wr = wr_en_i && (addr_i == AW'(A_CMD)) && (wr_data_i == DW'(CMD_ARM));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_run_o |-> !irq_o);

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend != '0));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_wr |=> ((pend & $past(pend)) == $past(pend)));

    p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en != {N_CH{1'b1}}) |=> ((pend & ~$past(pend) & ~$past(en)) == '0));

    p_arm_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> cnt_run_o);

    p_stop_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_o |-> !cnt_run_o);
endmodule

bind cntirq_hub cntirq_chk #(.N_CH(N_CH), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .irq_o     (irq_o),
    .cnt_run_o (cnt_run_o),
    .cnt_rst_o (cnt_rst_o),
    .pend      (pend_vec),
    .en        (en_vec)
);

// File: tb/cntirq_hub_tb.sv
module cntirq_hub_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [7:0] trig = 8'd0;
    logic [7:0] idx = 8'd0;
    logic [7:0] cok = 8'hFF;
    logic       irq, run, crst;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // reference state
    logic [7:0] m_pend, m_en, m_mon, m_prev;
    logic       m_run, m_rst;

    always #5 clk = ~clk;

    cntirq_hub u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wr_data_i(wdata), .rd_data_o(rdata), .trig_i(trig),
        .index_lvl_i(idx), .cable_ok_i(cok), .irq_o(irq),
        .cnt_run_o(run), .cnt_rst_o(crst)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_pend;
            3'd2: return m_en;
            3'd3: return ~(m_mon & ~cok);
            3'd4: return idx;
            default: return 8'h00;
        endcase
    endfunction

    // behavioural reference, updated at each active edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 0; m_en = 0; m_mon = 0; m_prev = 0; m_run = 0; m_rst = 0;
        end else begin
            logic [7:0] rise;
            bit         cmd;
            rise = trig & ~m_prev;
            cmd  = wr_en && addr == 3'd1;
            if (cmd && wdata == 8'h04) m_pend = 0;
            m_pend = m_pend | (rise & m_en);
            m_rst = cmd && wdata == 8'h01;
            if (cmd && wdata == 8'h04) m_run = 1;
            if (cmd && wdata == 8'h01) m_run = 0;
            if (wr_en && addr == 3'd2) m_en = wdata;
            if (wr_en && addr == 3'd3) m_mon = ~wdata;
            m_prev = trig;
        end
    end

    // per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            string rtag;
            chk("R7 irq", {7'd0, irq}, {7'd0, m_run & (|m_pend)});
            chk("R4 run", {7'd0, run}, {7'd0, m_run});
            chk("R6 rst pulse", {7'd0, crst}, {7'd0, m_rst});
            case (addr)
                3'd0: rtag = "R2 status";
                3'd2: rtag = "R11 enable";
                3'd3: rtag = "R9 cable";
                3'd4: rtag = "R10 level";
                default: rtag = "R11 zero read";
            endcase
            chk(rtag, rdata, m_read(addr));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] t);
        trig = t;
        tick();
        trig = 8'd0;
        tick();
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [7:0] exp);
        addr = a;
        @(negedge clk);
        chk(tag, rdata, exp);
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        cmp_on = 1'b1;
        // R1 reset state
        rd(3'd0, "R1 status", 8'h00);
        rd(3'd3, "R1 cable", 8'hFF);
        rd(3'd2, "R1 enable", 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 run", {7'd0, run}, 8'h00);
        // R2, R3: enables on 0, 3, 5; edges on 0, 1, 3
        wr(3'd2, 8'h29);
        pulse(8'h0B);
        rd(3'd0, "R3 masked edge", 8'h09);
        chk("R7 irq off while stopped", {7'd0, irq}, 8'h00);
        // R4 arm clears
        wr(3'd1, 8'h04);
        rd(3'd0, "R4 clear", 8'h00);
        chk("R4 run", {7'd0, run}, 8'h01);
        pulse(8'h20);
        rd(3'd0, "R2 latch", 8'h20);
        chk("R7 irq on", {7'd0, irq}, 8'h01);
        // R5 edge and clear together
        trig = 8'h01;
        wr(3'd1, 8'h04);
        rd(3'd0, "R5 edge wins", 8'h01);
        // R2 held level does not re-set
        wr(3'd1, 8'h04);
        rd(3'd0, "R2 level no retrigger", 8'h00);
        chk("R7 irq clear", {7'd0, irq}, 8'h00);
        trig = 8'h00;
        tick();
        // R8 other codes ignored
        pulse(8'h08);
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h02);
        wr(3'd1, 8'hFF);
        rd(3'd0, "R8 pend kept", 8'h08);
        chk("R8 run kept", {7'd0, run}, 8'h01);
        // R6 stop
        wr(3'd1, 8'h01);
        chk("R6 pulse high", {7'd0, crst}, 8'h01);
        chk("R6 run low", {7'd0, run}, 8'h00);
        tick();
        chk("R6 pulse one cycle", {7'd0, crst}, 8'h00);
        rd(3'd0, "R6 pend kept", 8'h08);
        chk("R7 irq gated", {7'd0, irq}, 8'h00);
        // R9 cable
        cok = 8'hAA;
        wr(3'd3, 8'hF0);
        rd(3'd3, "R9 fault view", 8'hFA);
        // R10 level
        idx = 8'h5C;
        rd(3'd4, "R10 level", 8'h5C);
        // R11 readback
        rd(3'd2, "R11 enable", 8'h29);
        rd(3'd1, "R11 cmd reads zero", 8'h00);
        rd(3'd6, "R11 hole reads zero", 8'h00);
        // pseudo-random traffic checked by the model every cycle
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            trig  = lfsr[7:0] ^ lfsr[15:8];
            idx   = lfsr[11:4];
            cok   = lfsr[13:6];
            wr_en = (lfsr[2:0] == 3'd0);
            addr  = 3'(lfsr[10:8] % 3'd6);
            case (lfsr[12:11])
                2'd0: wdata = 8'h01;
                2'd1: wdata = 8'h04;
                default: wdata = lfsr[15:8];
            endcase
            tick();
        end
        wr_en = 1'b0;
        tick();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule